// File: doc/BRIEF.md
# PLL Feedback Selector and Phase-Frequency Detector

This block is the digital front end of a clock-multiplying PLL, modelled in a fast sampling-clock domain. The reference, VCO and output clocks arrive as sampled levels. The block picks the feedback clock for the current PLL mode and divides the VCO clock when that mode needs it.

A two-latch phase-frequency detector compares the falling edges of the reference and feedback clocks. The reference latch raises UP and the feedback latch raises DOWN. Once both latches are set, they clear together after a fixed number of sampling cycles. At lock, both outputs therefore pulse briefly in every reference period, which keeps the loop out of a dead band.

The block also turns the multiplication factor into a coded gain setting for the charge pump. The analog charge pump, the loop filter and the VCO sit outside the block.

Top module: `pll_phase_front`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `up_o` and `dn_o` are low. In normal mode with `mfd_i` = 0, `fb_clk_o` is also low.
- R2: With `one_to_one_i` = 1 and `clkout_en_i` = 1, `fb_clk_o` equals `clkout_i` in the same cycle.
- R3: With `one_to_one_i` = 1 and `clkout_en_i` = 0, `fb_clk_o` is the VCO divided by two. The output toggles after every second sampled VCO level change and becomes visible one cycle after the sampling edge.
- R4: With `one_to_one_i` = 0, `fb_clk_o` is the VCO divided by `mfd_i`. The output toggles after every `mfd_i` sampled VCO level changes, with the same one-cycle latency as R3.
- R5: A falling edge is a sample of 1 followed by a sample of 0. A reference falling edge sets `up_o` in the next cycle, and a feedback falling edge sets `dn_o` in the next cycle. Each output then holds until it is cleared (R6). A feedback edge that lags the reference therefore gives an UP pulse whose width follows the lag, and a leading feedback edge gives a DOWN pulse.
- R6: Once `up_o` and `dn_o` are both high, both stay high for exactly RST_DLY cycles (default 2) and fall in the same cycle. Falling edges that arrive in that window are ignored. Falling edges that arrive in the same cycle therefore produce equal UP and DOWN pulses of RST_DLY cycles.
- R7: In normal mode, `gain_o` is 2'b00 (1X) for `mfd_i` below 2, 2'b01 (2X) for `mfd_i` from 2 to 5, and 2'b10 (4X) for `mfd_i` of 6 or more. The code 2'b11 never appears.
- R8: In 1:1 mode, `gain_o` is FIXED_GAIN (default 2'b00) for any `mfd_i`.
- R9: A change of `mfd_i` restarts the divider count without changing its output level. While `mfd_i` is 0, the divided output is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Sampled reference clock |
| vco_clk_i | input | 1 | Sampled VCO clock |
| clkout_i | input | 1 | Sampled system output clock |
| one_to_one_i | input | 1 | 1 selects 1:1 mode, 0 selects normal mode |
| clkout_en_i | input | 1 | Output clock enabled (used in 1:1 mode) |
| mfd_i | input | MFD_W | Multiplication factor |
| fb_clk_o | output | 1 | Selected feedback clock |
| up_o | output | 1 | Pump-up request |
| dn_o | output | 1 | Pump-down request |
| gain_o | output | 2 | Charge-pump gain code |

## Verification
The assertions assume that every clock input changes level at most once per sampling cycle and already belongs to the sampling domain. They also assume that `mfd_i` and the mode bits change only between sampling edges. The bench drives every input on the falling edge of the sampling clock, with clock half-periods of at least one sampling cycle. It changes the mode and the factor at arbitrary phases of the sampled clocks, so reloads and edges lost in the clearing window both occur. A behavioural model built from the requirements runs on every sampling edge and is compared with the block's outputs.

// File: rtl/pll_fe_pkg.sv
package pll_fe_pkg;
   typedef enum logic [1:0] {
      GAIN_1X = 2'b00,
      GAIN_2X = 2'b01,
      GAIN_4X = 2'b10
   } cp_gain_e;
endpackage

// File: rtl/pll_fb_divider.sv
module pll_fb_divider #(
   parameter int W = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         vco_i,
   input  logic [W-1:0] div_i,
   output logic         div_o
);
   logic         vco_q;
   logic [W-1:0] cnt_q;
   logic [W-1:0] div_q;
   logic         out_q;
   logic         vco_edge;

   assign vco_edge = vco_q ^ vco_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vco_q <= 1'b0;
         cnt_q <= '0;
         div_q <= '0;
         out_q <= 1'b0;
      end else begin
         vco_q <= vco_i;
         div_q <= div_i;
         if (div_i == '0) begin
            cnt_q <= '0;
            out_q <= 1'b0;
         end else if (div_i != div_q) begin
            cnt_q <= '0;
         end else if (vco_edge) begin
            if (cnt_q == div_i - 1'b1) begin
               cnt_q <= '0;
               out_q <= ~out_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign div_o = out_q;

   // R9
   zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_i == '0) |=> !div_o);

   // R4
   toggle_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_o != $past(div_o)) |-> ($past(vco_edge) || $past(div_i) == '0));
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd #(
   parameter int RST_DLY = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ref_i,
   input  logic fb_i,
   output logic up_o,
   output logic dn_o
);
   logic ref_q, fb_q;
   logic up_q, dn_q;
   logic both, clr;
   logic ref_fall, fb_fall;

   assign ref_fall = ref_q & ~ref_i;
   assign fb_fall  = fb_q & ~fb_i;
   assign both     = up_q & dn_q;

   generate
      if (RST_DLY == 1) begin : g_nodly
         assign clr = both;
      end else begin : g_dly
         localparam int CW = $clog2(RST_DLY);
         logic [CW-1:0] cnt_q;
         assign clr = both && (cnt_q == CW'(RST_DLY - 1));
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)             cnt_q <= '0;
            else if (both && !clr)   cnt_q <= cnt_q + 1'b1;
            else                     cnt_q <= '0;
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_q <= 1'b0;
         fb_q  <= 1'b0;
         up_q  <= 1'b0;
         dn_q  <= 1'b0;
      end else begin
         ref_q <= ref_i;
         fb_q  <= fb_i;
         if (both) begin
            if (clr) begin
               up_q <= 1'b0;
               dn_q <= 1'b0;
            end
         end else begin
            up_q <= up_q | ref_fall;
            dn_q <= dn_q | fb_fall;
         end
      end
   end

   assign up_o = up_q;
   assign dn_o = dn_q;

   // R6
   joint_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(up_q) |-> $fell(dn_q));

   // R6
   clear_after_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(up_q) |-> $past(up_q && dn_q));

   // R5
   up_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(up_q) |-> $past(ref_q && !ref_i));

   // R5
   dn_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(dn_q) |-> $past(fb_q && !fb_i));
endmodule

// File: rtl/pll_cp_gain.sv
module pll_cp_gain
   import pll_fe_pkg::*;
#(
   parameter int         W          = 4,
   parameter logic [1:0] FIXED_GAIN = 2'b00
) (
   input  logic         one_to_one_i,
   input  logic [W-1:0] mfd_i,
   output logic [1:0]   gain_o
);
   cp_gain_e g;
   always_comb begin
      if (one_to_one_i)                 g = cp_gain_e'(FIXED_GAIN);
      else if (mfd_i < W'(2))           g = GAIN_1X;
      else if (mfd_i < W'(6))           g = GAIN_2X;
      else                              g = GAIN_4X;
   end
   assign gain_o = g;
endmodule

// File: rtl/pll_phase_front.sv
module pll_phase_front
   import pll_fe_pkg::*;
#(
   parameter int         MFD_W      = 4,
   parameter int         RST_DLY    = 2,
   parameter logic [1:0] FIXED_GAIN = 2'b00
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ref_clk_i,
   input  logic             vco_clk_i,
   input  logic             clkout_i,
   input  logic             one_to_one_i,
   input  logic             clkout_en_i,
   input  logic [MFD_W-1:0] mfd_i,
   output logic             fb_clk_o,
   output logic             up_o,
   output logic             dn_o,
   output logic [1:0]       gain_o
);
   localparam logic [MFD_W-1:0] HALF_DIV = MFD_W'(2);

   generate
      if (MFD_W < 3) begin : g_bad_w
         $error("MFD_W must allow factors of 6 and above");
      end
      if (RST_DLY < 1) begin : g_bad_dly
         $error("RST_DLY must be at least 1");
      end
      if (FIXED_GAIN == 2'b11) begin : g_bad_gain
         $error("FIXED_GAIN must be a legal gain code");
      end
   endgenerate

   logic div_n, div_2, fb;

   pll_fb_divider #(.W(MFD_W)) u_div_n (
      .clk_i(clk_i), .rst_ni(rst_ni), .vco_i(vco_clk_i),
      .div_i(mfd_i), .div_o(div_n));

   pll_fb_divider #(.W(MFD_W)) u_div_2 (
      .clk_i(clk_i), .rst_ni(rst_ni), .vco_i(vco_clk_i),
      .div_i(HALF_DIV), .div_o(div_2));

   always_comb begin
      if (one_to_one_i) fb = clkout_en_i ? clkout_i : div_2;
      else              fb = div_n;
   end

   pll_pfd #(.RST_DLY(RST_DLY)) u_pfd (
      .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_clk_i), .fb_i(fb),
      .up_o(up_o), .dn_o(dn_o));

   pll_cp_gain #(.W(MFD_W), .FIXED_GAIN(FIXED_GAIN)) u_gain (
      .one_to_one_i(one_to_one_i), .mfd_i(mfd_i), .gain_o(gain_o));

   assign fb_clk_o = fb;

   // R7
   legal_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gain_o != 2'b11);

   // R2
   clkout_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (one_to_one_i && clkout_en_i) |-> (fb_clk_o == clkout_i));
endmodule

// File: tb/pll_phase_front_tb.sv
module pll_phase_front_tb;
   localparam int D = 2;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_c = 1'b0, vco = 1'b0, own_clkout = 1'b0;
   logic tie = 1'b0;
   logic one = 1'b0, en = 1'b0;
   logic [3:0] mfd = 4'd0;
   logic fb, up, dn;
   logic [1:0] gain;
   logic clkout;
   int ref_half = 16, vco_half = 2, co_half = 8;
   int checks = 0, errors = 0;
   bit done = 0;

   assign clkout = tie ? ref_c : own_clkout;

   always #4 clk = ~clk;

   pll_phase_front u_dut (
      .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_c), .vco_clk_i(vco),
      .clkout_i(clkout), .one_to_one_i(one), .clkout_en_i(en), .mfd_i(mfd),
      .fb_clk_o(fb), .up_o(up), .dn_o(dn), .gain_o(gain));

   initial forever begin repeat (ref_half) @(negedge clk); ref_c = ~ref_c; end
   initial forever begin repeat (vco_half) @(negedge clk); vco = ~vco; end
   initial forever begin repeat (co_half) @(negedge clk); own_clkout = ~own_clkout; end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_gain(input bit o, input int m);
      if (o) return 0;
      if (m < 2) return 0;
      if (m < 6) return 1;
      return 2;
   endfunction

   // behavioural reference model
   int vq = 0, cn = 0, on = 0, mq = 0, c2 = 0, o2 = 0, m2q = 0;
   int rq = 0, fq = 0, mu = 0, md = 0, pc = 0;
   bit cmp_en = 0;

   function automatic int sel_fb(input int n_out, input int t_out);
      if (one) return en ? int'(clkout) : t_out;
      return n_out;
   endfunction

   always @(posedge clk) begin
      int fbv, rf, ff, m, ve;
      if (!rst_n) begin
         vq = 0; cn = 0; on = 0; mq = 0; c2 = 0; o2 = 0; m2q = 0;
         rq = 0; fq = 0; mu = 0; md = 0; pc = 0;
      end else begin
         m   = int'(mfd);
         fbv = sel_fb(on, o2);
         rf  = (rq == 1 && ref_c == 1'b0) ? 1 : 0;
         ff  = (fq == 1 && fbv == 0) ? 1 : 0;
         if (mu == 1 && md == 1) begin
            if (pc == D - 1) begin mu = 0; md = 0; pc = 0; end
            else pc++;
         end else begin
            if (rf == 1) mu = 1;
            if (ff == 1) md = 1;
            pc = 0;
         end
         rq = int'(ref_c); fq = fbv;
         ve = (int'(vco) != vq) ? 1 : 0;
         if (m == 0) begin cn = 0; on = 0; end
         else if (m != mq) cn = 0;
         else if (ve == 1) begin
            if (cn == m - 1) begin cn = 0; on = 1 - on; end else cn++;
         end
         mq = m;
         if (m2q != 2) c2 = 0;
         else if (ve == 1) begin
            if (c2 == 1) begin c2 = 0; o2 = 1 - o2; end else c2++;
         end
         m2q = 2;
         vq = int'(vco);
      end
      #2;
      if (cmp_en && rst_n) begin
         int ef;
         ef = sel_fb(on, o2);
         // R2 R3 R4 R9 feedback path
         check(int'(fb) == ef, "R2/R3/R4/R9 fb", int'(fb), ef);
         // R5 R6 detector outputs
         check(int'(up) == mu, "R5/R6 up", int'(up), mu);
         check(int'(dn) == md, "R5/R6 dn", int'(dn), md);
         // R7 R8 gain
         check(int'(gain) == exp_gain(one, int'(mfd)), "R7/R8 gain",
               int'(gain), exp_gain(one, int'(mfd)));
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int highs, mism;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(up == 1'b0 && dn == 1'b0, "R1 reset up/dn", int'({up, dn}), 0);
      check(fb == 1'b0, "R1 reset fb", int'(fb), 0);
      rst_n = 1'b1;
      @(posedge clk); #2;
      check(up == 1'b0 && dn == 1'b0, "R1 first cycle up/dn", int'({up, dn}), 0);
      cmp_en = 1;

      // R4 normal mode, divide by 4, frequency mismatch
      @(negedge clk); mfd = 4'd4;
      repeat (400) @(negedge clk);
      // R4 near lock, divide by 8
      ref_half = 16; vco_half = 2; mfd = 4'd8;
      repeat (400) @(negedge clk);
      // R9 change factor mid-count, odd factor
      mfd = 4'd3; repeat (37) @(negedge clk);
      mfd = 4'd5; repeat (300) @(negedge clk);

      // R9 zero factor holds feedback low
      mfd = 4'd0;
      @(negedge clk);
      mism = 0;
      for (int i = 0; i < 64; i++) begin
         @(posedge clk); #2;
         if (fb != 1'b0) mism++;
      end
      check(mism == 0, "R9 zero factor low", mism, 0);

      // R3 1:1 mode, output clock disabled
      @(negedge clk); one = 1'b1; en = 1'b0; mfd = 4'd7; ref_half = 4; vco_half = 1;
      repeat (300) @(negedge clk);
      vco_half = 3; repeat (200) @(negedge clk);

      // R2 1:1 mode, output clock enabled
      en = 1'b1; co_half = 5; ref_half = 6;
      repeat (300) @(negedge clk);

      // R6 lock: feedback edges coincide with reference edges
      tie = 1'b1; ref_half = 8;
      repeat (40) @(negedge clk);
      highs = 0; mism = 0;
      for (int i = 0; i < 160; i++) begin
         @(posedge clk); #2;
         if (up != dn) mism++;
         if (up) highs++;
      end
      check(mism == 0, "R6 equal pulses at lock", mism, 0);
      check(highs == 10 * D, "R6 pulse total at lock", highs, 10 * D);
      tie = 1'b0;

      // R7 R8 gain sweep in both modes
      for (int o = 0; o < 2; o++) begin
         for (int m = 0; m < 16; m++) begin
            @(negedge clk); one = o[0]; mfd = m[3:0]; #1;
            check(int'(gain) == exp_gain(o[0], m), o ? "R8 fixed gain" : "R7 gain table",
                  int'(gain), exp_gain(o[0], m));
         end
      end

      // R5 wide lead and lag in normal mode
      one = 1'b0; mfd = 4'd6; vco_half = 1; ref_half = 7;
      repeat (400) @(negedge clk);
      ref_half = 5; repeat (400) @(negedge clk);
      finish_run();
   end
endmodule